// File: doc/BRIEF.md
# Ethernet Receive Frame Classifier

This block sits behind a receive MAC front end and takes one byte per clock, qualified by a valid strobe. A start marker flags the first byte of each frame and an end marker flags its last byte. The block skips any leading run of 0x55 bytes and looks for the 0xD5 delimiter. Counting from the byte after the delimiter, it reads the destination address, the source address and the 16-bit Length/Type word. It reports these together with two decisions: whether the destination is a group address, and whether the 16-bit word names a protocol type or gives a data length.

Bytes after the 14-byte header are passed out as payload. The last four bytes of the frame are the check sequence and are never forwarded. One cycle after the end marker, a status pulse reports the CRC result, a size violation flag and an overall good flag. A frame whose delimiter never shows up in the allowed window produces no output at all. There is no backpressure: every valid byte is consumed in its own cycle.

Top module: `eth_rx_classifier`

## Requirements
- R1: After reset, outValid, hdrValid and statValid are low, and they stay low until a frame delivers bytes.
- R2: A frame may open with 0 to 7 bytes of 0x55 before the 0xD5 delimiter. These bytes, and the delimiter, produce no output. The first frame byte is the byte after the delimiter.
- R3: The frame is dropped with no header, payload or status output in two cases: 0xD5 is not among the first 8 bytes after the start marker, or a byte other than 0x55 comes before it.
- R4: hdrValid pulses one cycle after the 14th frame byte is accepted. At that pulse, dstAddr holds frame bytes 1 to 6 with byte 1 in bits 47:40. srcAddr holds bytes 7 to 12 in the same order. lenType holds bytes 13 and 14, with byte 13 as the high byte. These outputs change only at a hdrValid pulse.
- R5: isMulticast equals bit 0 of the first destination byte (1 means group, 0 means individual).
- R6: isType is 1 when lenType is 1536 or more, and 0 when it is smaller.
- R7: Frame bytes 15 through the fifth-from-last come out on outData with outValid high. Byte k appears one cycle after byte k+4 is accepted. The four trailing check bytes are never output.
- R8: Every frame whose delimiter was found, and that was not restarted, produces exactly one statValid pulse, one cycle after its end-marked byte. The status outputs change only at that pulse.
- R9: statFcsOk is 1 when the CRC-32 over all frame bytes, including the four check bytes, leaves the residue. The CRC uses the reflected generator 0x04C11DB7, starts at all ones and is inverted on transmit, with check bytes sent low byte first. In the reflected shift register used here, the residue reads 0xDEBB20E3.
- R10: statSizeErr is 1 when the frame length is below 64 or above 1518 bytes, counting from the first destination byte through the last check byte. This includes a frame that ends on the delimiter itself.
- R11: statGood is 1 exactly when statFcsOk is 1 and statSizeErr is 0.
- R12: A start marker that arrives inside a frame abandons that frame without status and restarts the delimiter search on that byte.
- R13: Cycles with inValid low have no effect. Valid bytes after an end marker and before the next start marker are ignored, even when they equal 0xD5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A byte is present on inData this cycle |
| inData | input | 8 | Received byte |
| inSof | input | 1 | Marks the first byte of a frame |
| inEof | input | 1 | Marks the last byte of a frame |
| outValid | output | 1 | Payload byte valid |
| outData | output | 8 | Payload byte |
| hdrValid | output | 1 | Header fields updated this cycle |
| dstAddr | output | 48 | Destination address |
| srcAddr | output | 48 | Source address |
| lenType | output | 16 | Length/Type word |
| isMulticast | output | 1 | Destination is a group address |
| isType | output | 1 | lenType is a type code (not a length) |
| statValid | output | 1 | End-of-frame status valid |
| statFcsOk | output | 1 | CRC residue matched |
| statSizeErr | output | 1 | Frame length outside limits |
| statGood | output | 1 | CRC good and size within limits |

## Verification
The assertions take the following for granted about the inputs:
- inSof and inEof are only meaningful together with inValid.
- inSof appears only on the first byte of a frame, and inEof only on its last byte.
- Each valid byte is consumed in its own cycle.

Under those assumptions, the properties tie every output pulse to an accepted byte in the cycle before. They also tie the number of forwarded payload bytes to a size-clean status. The stimulus drives markers and bytes only at the falling clock edge and raises a marker only on a real frame edge. It covers the following cases:
- gapped and dense byte streams;
- abandoned frames;
- bytes left outside any frame;
- a delimiter that carries the end marker.

// File: rtl/eth_rxc_pkg.sv
package eth_rxc_pkg;

  localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE      = 8'hD5;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_ONES      = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE   = 32'hDEBB20E3;
  localparam int          HDR_BYTES     = 14;
  localparam int          FCS_BYTES     = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_BODY,
    ST_DROP
  } rxState_t;

  // strobes from control to datapath, one set per accepted byte
  typedef struct packed {
    logic crcInit;
    logic crcEn;
    logic hdrShift;
    logic hdrDone;
    logic pipeShift;
    logic emit;
    logic frameEnd;
    logic sizeErr;
  } rxCtl_t;

  // one byte of reflected CRC-32, least significant bit first
  function automatic logic [31:0] crc32Byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? CRC_POLY_REFL : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_rxc_ctrl.sv
module eth_rxc_ctrl
  import eth_rxc_pkg::*;
#(
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int SFD_WINDOW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inSof,
  input  logic       inEof,
  output rxCtl_t     ctl
);

  localparam int CNT_W  = $clog2(MAX_FRAME + 1);
  localparam int HUNT_W = $clog2(SFD_WINDOW + 1);
  localparam logic [CNT_W-1:0]  CNT_SAT    = CNT_W'(MAX_FRAME);
  localparam logic [CNT_W-1:0]  HDR_LAST   = CNT_W'(HDR_BYTES - 1);
  localparam logic [CNT_W-1:0]  HDR_END    = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0]  EMIT_FIRST = CNT_W'(HDR_BYTES + FCS_BYTES);
  localparam logic [CNT_W-1:0]  SHORT_LIM  = CNT_W'(MIN_FRAME - 1);
  localparam logic [CNT_W-1:0]  LONG_LIM   = CNT_W'(MAX_FRAME - 1);
  localparam logic [HUNT_W-1:0] HUNT_LAST  = HUNT_W'(SFD_WINDOW - 1);

  rxState_t          state, stateNext;
  logic [CNT_W-1:0]  frameCnt, frameCntNext;
  logic [HUNT_W-1:0] huntCnt, huntCntNext, huntPos;
  logic              hunting;

  assign huntPos = inSof ? '0 : huntCnt;
  assign hunting = inSof || (state == ST_HUNT);

  always_comb begin
    ctl          = '0;
    stateNext    = state;
    frameCntNext = frameCnt;
    huntCntNext  = huntCnt;
    if (inValid) begin
      if (hunting) begin
        if (inData == SFD_BYTE) begin
          ctl.crcInit  = 1'b1;
          frameCntNext = '0;
          stateNext    = ST_BODY;
          if (inEof) begin
            // empty frame: delimiter carries the end marker
            ctl.frameEnd = 1'b1;
            ctl.sizeErr  = 1'b1;
            stateNext    = ST_IDLE;
          end
        end else if ((inData == PREAMBLE_BYTE) && (huntPos < HUNT_LAST)) begin
          huntCntNext = huntPos + 1'b1;
          stateNext   = inEof ? ST_IDLE : ST_HUNT;
        end else begin
          stateNext = inEof ? ST_IDLE : ST_DROP;
        end
      end else if (state == ST_BODY) begin
        ctl.crcEn     = 1'b1;
        ctl.hdrShift  = frameCnt < HDR_END;
        ctl.hdrDone   = frameCnt == HDR_LAST;
        ctl.pipeShift = frameCnt >= HDR_END;
        ctl.emit      = frameCnt >= EMIT_FIRST;
        if (frameCnt != CNT_SAT) begin
          frameCntNext = frameCnt + 1'b1;
        end
        if (inEof) begin
          ctl.frameEnd = 1'b1;
          ctl.sizeErr  = (frameCnt < SHORT_LIM) || (frameCnt > LONG_LIM);
          stateNext    = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      frameCnt <= '0;
      huntCnt  <= '0;
    end else begin
      state    <= stateNext;
      frameCnt <= frameCntNext;
      huntCnt  <= huntCntNext;
    end
  end

endmodule

// File: rtl/eth_rxc_dpath.sv
module eth_rxc_dpath
  import eth_rxc_pkg::*;
#(
  parameter int TYPE_MIN = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  inData,
  input  rxCtl_t      ctl,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        hdrValid,
  output logic [47:0] dstAddr,
  output logic [47:0] srcAddr,
  output logic [15:0] lenType,
  output logic        isMulticast,
  output logic        isType,
  output logic        statValid,
  output logic        statFcsOk,
  output logic        statSizeErr,
  output logic        statGood
);

  localparam int HDR_W = 8 * HDR_BYTES;

  logic [31:0]        crcReg, crcNext;
  logic [HDR_W-9:0]   hdrSh;
  logic [HDR_W-1:0]   hdrFull;
  logic [7:0]         pipe [FCS_BYTES];
  logic               fcsMatch;

  always_comb begin
    crcNext = crcReg;
    if (ctl.crcInit) begin
      crcNext = CRC_ONES;
    end else if (ctl.crcEn) begin
      crcNext = crc32Byte(crcReg, inData);
    end
  end

  assign fcsMatch = crcNext == CRC_RESIDUE;
  assign hdrFull  = {hdrSh, inData};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg <= CRC_ONES;
      hdrSh  <= '0;
    end else begin
      crcReg <= crcNext;
      if (ctl.hdrShift) begin
        hdrSh <= hdrFull[HDR_W-9:0];
      end
    end
  end

  // check-sequence holdback: payload leaves once four later bytes arrived
  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe[g] <= '0;
      end else if (ctl.pipeShift) begin
        if (g == 0) begin
          pipe[g] <= inData;
        end else begin
          pipe[g] <= pipe[(g == 0) ? 0 : g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outData     <= '0;
      hdrValid    <= 1'b0;
      dstAddr     <= '0;
      srcAddr     <= '0;
      lenType     <= '0;
      isMulticast <= 1'b0;
      isType      <= 1'b0;
      statValid   <= 1'b0;
      statFcsOk   <= 1'b0;
      statSizeErr <= 1'b0;
      statGood    <= 1'b0;
    end else begin
      outValid  <= ctl.emit;
      hdrValid  <= ctl.hdrDone;
      statValid <= ctl.frameEnd;
      if (ctl.emit) begin
        outData <= pipe[FCS_BYTES-1];
      end
      if (ctl.hdrDone) begin
        dstAddr     <= hdrFull[HDR_W-1 -: 48];
        srcAddr     <= hdrFull[HDR_W-49 -: 48];
        lenType     <= hdrFull[15:0];
        isMulticast <= hdrFull[HDR_W-8];
        isType      <= hdrFull[15:0] >= 16'(TYPE_MIN);
      end
      if (ctl.frameEnd) begin
        statFcsOk   <= fcsMatch;
        statSizeErr <= ctl.sizeErr;
        statGood    <= fcsMatch && !ctl.sizeErr;
      end
    end
  end

endmodule

// File: rtl/eth_rx_classifier.sv
module eth_rx_classifier
  import eth_rxc_pkg::*;
#(
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int SFD_WINDOW = 8,
  parameter int TYPE_MIN   = 1536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [7:0]  inData,
  input  logic        inSof,
  input  logic        inEof,
  output logic        outValid,
  output logic [7:0]  outData,
  output logic        hdrValid,
  output logic [47:0] dstAddr,
  output logic [47:0] srcAddr,
  output logic [15:0] lenType,
  output logic        isMulticast,
  output logic        isType,
  output logic        statValid,
  output logic        statFcsOk,
  output logic        statSizeErr,
  output logic        statGood
);

  rxCtl_t ctl;

  eth_rxc_ctrl #(
    .MIN_FRAME (MIN_FRAME),
    .MAX_FRAME (MAX_FRAME),
    .SFD_WINDOW(SFD_WINDOW)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .inValid(inValid),
    .inData (inData),
    .inSof  (inSof),
    .inEof  (inEof),
    .ctl    (ctl)
  );

  eth_rxc_dpath #(
    .TYPE_MIN(TYPE_MIN)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .inData     (inData),
    .ctl        (ctl),
    .outValid   (outValid),
    .outData    (outData),
    .hdrValid   (hdrValid),
    .dstAddr    (dstAddr),
    .srcAddr    (srcAddr),
    .lenType    (lenType),
    .isMulticast(isMulticast),
    .isType     (isType),
    .statValid  (statValid),
    .statFcsOk  (statFcsOk),
    .statSizeErr(statSizeErr),
    .statGood   (statGood)
  );

endmodule

// File: rtl/eth_rx_classifier_chk.sv
module eth_rx_classifier_chk #(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518
) (
  input logic        clk,
  input logic        rst_n,
  input logic        inValid,
  input logic        inEof,
  input logic        outValid,
  input logic        hdrValid,
  input logic [47:0] dstAddr,
  input logic [15:0] lenType,
  input logic        statValid,
  input logic        statSizeErr,
  input logic        statGood
);

  localparam int PAY_MIN = MIN_FRAME - 18;
  localparam int PAY_MAX = MAX_FRAME - 18;

  logic [15:0] payCnt;
  logic        hdrSeen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      payCnt  <= '0;
      hdrSeen <= 1'b0;
    end else begin
      if (statValid || hdrValid) begin
        payCnt <= '0;
      end else if (outValid) begin
        payCnt <= payCnt + 1'b1;
      end
      if (hdrValid) begin
        hdrSeen <= 1'b1;
      end else if (statValid) begin
        hdrSeen <= 1'b0;
      end
    end
  end

  // R7
  payload_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> hdrSeen);

  // R10
  size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statValid && !statSizeErr) |->
      ((32'(payCnt) + 32'(outValid)) >= PAY_MIN) && ((32'(payCnt) + 32'(outValid)) <= PAY_MAX));

  // R8
  stat_follows_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statValid |-> $past(inValid && inEof));

  // R4
  hdr_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdrValid |-> $past(inValid));

  // R4
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hdrValid |-> ($stable(dstAddr) && $stable(lenType)));

  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !statValid |-> $stable(statGood));

  // R13
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(inValid) |-> (!outValid && !hdrValid && !statValid));

endmodule

bind eth_rx_classifier eth_rx_classifier_chk #(
  .MIN_FRAME(MIN_FRAME),
  .MAX_FRAME(MAX_FRAME)
) u_chk (.*);

// File: tb/eth_rx_classifier_bench.sv
`timescale 1ns/1ps
module eth_rx_classifier_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = '0;
  logic        inSof = 1'b0;
  logic        inEof = 1'b0;
  logic        outValid;
  logic [7:0]  outData;
  logic        hdrValid;
  logic [47:0] dstAddr;
  logic [47:0] srcAddr;
  logic [15:0] lenType;
  logic        isMulticast;
  logic        isType;
  logic        statValid;
  logic        statFcsOk;
  logic        statSizeErr;
  logic        statGood;

  always #4 clk = ~clk;

  eth_rx_classifier u_eth_rx_classifier (.*);

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  // expectations for the next falling edge
  bit          expOutV, expHdrV, expStatV;
  logic [7:0]  expOutD;
  logic [47:0] expDst, expSrc;
  logic [15:0] expLt;
  bit          expFcs, expSize;

  // current frame
  logic [7:0]  frm [$];
  logic [47:0] fDst, fSrc;
  logic [15:0] fLt;
  bit          fCorrupt;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk(outValid == expOutV, "R7 outValid", 64'(outValid), 64'(expOutV));
    if (expOutV) chk(outData == expOutD, "R7 outData", 64'(outData), 64'(expOutD));
    chk(hdrValid == expHdrV, "R4 hdrValid", 64'(hdrValid), 64'(expHdrV));
    if (expHdrV) begin
      chk(dstAddr == expDst, "R4 dstAddr", 64'(dstAddr), 64'(expDst));
      chk(srcAddr == expSrc, "R4 srcAddr", 64'(srcAddr), 64'(expSrc));
      chk(lenType == expLt, "R4 lenType", 64'(lenType), 64'(expLt));
      chk(isMulticast == expDst[40], "R5 isMulticast", 64'(isMulticast), 64'(expDst[40]));
      chk(isType == (int'(expLt) >= 1536), "R6 isType", 64'(isType), 64'(int'(expLt) >= 1536));
    end
    chk(statValid == expStatV, "R8 statValid", 64'(statValid), 64'(expStatV));
    if (expStatV) begin
      chk(statFcsOk == expFcs, "R9 statFcsOk", 64'(statFcsOk), 64'(expFcs));
      chk(statSizeErr == expSize, "R10 statSizeErr", 64'(statSizeErr), 64'(expSize));
      chk(statGood == (expFcs && !expSize), "R11 statGood", 64'(statGood), 64'(expFcs && !expSize));
    end
  endtask

  task automatic step(input bit v, input logic [7:0] b, input bit s, input bit e);
    @(negedge clk);
    compare();
    inValid  = v;
    inData   = b;
    inSof    = s;
    inEof    = e;
    expOutV  = 0;
    expHdrV  = 0;
    expStatV = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
  endtask

  function automatic logic [31:0] crcStep(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] != d[i]) r = {1'b0, r[31:1]} ^ 32'hEDB88320;
      else              r = {1'b0, r[31:1]};
    end
    return r;
  endfunction

  task automatic build(input logic [47:0] d, input logic [47:0] s, input logic [15:0] lt,
                       input int pay, input int seed, input bit corrupt);
    logic [31:0] c;
    frm.delete();
    fDst = d; fSrc = s; fLt = lt; fCorrupt = corrupt;
    for (int i = 0; i < 6; i++) frm.push_back(d[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) frm.push_back(s[47-8*i -: 8]);
    frm.push_back(lt[15:8]);
    frm.push_back(lt[7:0]);
    for (int i = 0; i < pay; i++) frm.push_back(8'((seed + i * 7) & 255));
    c = 32'hFFFFFFFF;
    foreach (frm[i]) c = crcStep(c, frm[i]);
    c = ~c;
    for (int i = 0; i < 4; i++) frm.push_back(c[8*i +: 8]);
    if (corrupt) frm[16] = frm[16] ^ 8'h01;
  endtask

  // pre: preamble bytes; gap: idle before every gap-th byte (0 none); cut: bytes sent when no end marker
  task automatic send(input int pre, input int gap, input bit withEof, input int cut);
    int n;
    int sz;
    sz = frm.size();
    n = withEof ? sz : cut;
    for (int p = 0; p < pre; p++) step(1, 8'h55, p == 0, 0);
    step(1, 8'hD5, pre == 0, 0);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) step(0, 8'h00, 0, 0);
      step(1, frm[i], 0, withEof && (i == n - 1));
      if (i >= 18) begin
        expOutV = 1;
        expOutD = frm[i-4];
      end
      if (i == 13) begin
        expHdrV = 1;
        expDst = fDst; expSrc = fSrc; expLt = fLt;
      end
      if (withEof && i == n - 1) begin
        expStatV = 1;
        expFcs   = !fCorrupt;
        expSize  = (sz < 64) || (sz > 1518);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    expOutV = 0; expHdrV = 0; expStatV = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!outValid && !hdrValid && !statValid, "R1 reset valids", 64'({outValid, hdrValid, statValid}), 64'(0));
    rst_n = 1'b1;
    idle(3);

    // R2 longest preamble, R10 minimum size, unicast type frame
    build(48'h0200_1122_3344, 48'h0A0B_0C0D_0E0F, 16'h0800, 46, 3, 0);
    send(7, 0, 1, 0);
    idle(2);

    // R2 no preamble, R5 group address, R6 length, R13 gaps
    build(48'h0100_5E00_0001, 48'h0200_0000_0007, 16'h002E, 46, 90, 0);
    send(0, 3, 1, 0);
    idle(2);

    // R6 boundary below and at 1536
    build(48'h0300_0000_0001, 48'h0000_0000_0002, 16'h05FF, 50, 17, 0);
    send(2, 0, 1, 0);
    build(48'h0400_0000_0001, 48'h0000_0000_0003, 16'h0600, 50, 40, 0);
    send(1, 0, 1, 0);
    idle(1);

    // R9 / R11 corrupted check bytes
    build(48'h0200_0000_00AA, 48'h0200_0000_00BB, 16'h0800, 60, 5, 1);
    send(3, 0, 1, 0);
    idle(1);

    // R10 short frame with good CRC
    build(48'h0200_0000_0010, 48'h0200_0000_0020, 16'h000A, 10, 8, 0);
    send(1, 0, 1, 0);
    // R10 just under minimum
    build(48'h0200_0000_0011, 48'h0200_0000_0021, 16'h002D, 45, 9, 0);
    send(1, 0, 1, 0);
    idle(1);

    // R10 maximum and one over
    build(48'h0600_0000_0001, 48'h0600_0000_0002, 16'h05DC, 1500, 77, 0);
    send(7, 0, 1, 0);
    build(48'h0700_0000_0001, 48'h0700_0000_0002, 16'h0800, 1501, 33, 0);
    send(7, 0, 1, 0);
    idle(2);

    // R3 delimiter past the window: nothing expected
    build(48'h0200_0000_0030, 48'h0200_0000_0031, 16'h0800, 46, 1, 0);
    for (int p = 0; p < 8; p++) step(1, 8'h55, p == 0, 0);
    step(1, 8'hD5, 0, 0);
    foreach (frm[i]) step(1, frm[i], 0, i == frm.size() - 1);
    // R3 foreign byte before the delimiter
    step(1, 8'h55, 1, 0);
    step(1, 8'hAA, 0, 0);
    step(1, 8'hD5, 0, 0);
    foreach (frm[i]) step(1, frm[i], 0, i == frm.size() - 1);
    idle(2);

    // R13 bytes outside any frame, including a delimiter value
    step(1, 8'hD5, 0, 0);
    step(1, 8'h55, 0, 0);
    step(1, 8'hD5, 0, 1);
    step(1, 8'h12, 0, 0);
    idle(2);

    // R12 frame abandoned by a new start marker, then a clean frame
    build(48'h0200_0000_0040, 48'h0200_0000_0041, 16'h0800, 80, 61, 0);
    send(2, 0, 0, 30);
    build(48'h0100_0000_0042, 48'h0200_0000_0043, 16'h0800, 64, 62, 0);
    send(4, 0, 1, 0);
    idle(2);

    // R10 delimiter carrying the end marker: empty frame
    step(1, 8'h55, 1, 0);
    step(1, 8'hD5, 0, 1);
    expStatV = 1; expFcs = 0; expSize = 1;
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule